// File: doc/BRIEF.md
# Firmware-Hub Cycle Header Decoder

This block sits on the target side of a nibble-wide firmware-hub bus and turns the header of a memory cycle into one decoded request. On every clock it samples the 4-bit bus and an active-low frame strobe. It keeps the nibble seen on the final low-strobe clock as the start code. It compares the next nibble with the strapped device ID, then gathers a seven-nibble address with the most significant nibble first. Last, it checks the transfer-size nibble.

A header that passes every check produces a single-clock request pulse. With the pulse come a read/write flag, a flag that picks the memory array or the register space, and the low 19 address bits. A header that fails a check is dropped quietly. Data phase, turnaround, sync and storage are handled by downstream logic.

Top module: `fwh_hdr_decoder`

## Requirements
- R1: The start code is the bus nibble sampled on the last clock on which `frame_n` is low. A start code of 1101b gives a read (`req_write`=0) and 1110b gives a write (`req_write`=1).
- R2: A start code other than 1101b or 1110b never produces a request.
- R3: The select nibble is sampled on the first clock with `frame_n` high after the start code. If it differs from `id_strap`, no request is produced for that cycle.
- R4: The seven nibbles after the select nibble form a 28-bit address, most significant nibble first. `req_addr` carries bits 18 to 0 of that address.
- R5: `req_mem` equals address bit 22: 1 means the memory array, 0 means register space.
- R6: Address bits 27 to 23 and 21 to 19 have no effect on any output.
- R7: The nibble after the seventh address nibble is the size. Only 0000b yields a request; any other value drops the cycle.
- R8: If `frame_n` is sampled low before the size nibble has been sampled with `frame_n` high, the header in progress is dropped. The nibble on that clock is treated as a new start candidate.
- R9: After a good size nibble, `req_valid` is high for exactly one clock: the clock after the size nibble is sampled. `req_write`, `req_mem` and `req_addr` are valid during that clock.
- R10: A synchronous active-high `rst` clears all outputs to zero and drops any header in progress.
- R11: A new frame may begin on the clock right after the size nibble. Both headers then produce their own requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe |
| bus_nib | input | 4 | Sampled nibble from the shared data bus |
| id_strap | input | 4 | Strapped device ID compared with the select nibble |
| req_valid | output | 1 | One-clock pulse when a header has been decoded |
| req_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| req_mem | output | 1 | 1 for the memory array, 0 for register space |
| req_addr | output | 19 | Effective address bits 18 to 0 |

## Verification
Two behaviours can land on the same clock edge: a header completing, and a frame strobe that either aborts the header or starts the next one.

Two directed cases provoke this edge:
- The strobe is pulled low on the clock that carries the size nibble. This must abort the header and give no pulse.
- The strobe is pulled low on the clock right after the size nibble. This must keep the pending pulse, and the new header must decode as well.

Each is judged by counting pulses and comparing the fields of the last pulse with values computed from the driven nibbles. Seeded random headers then mix start codes, select values, size codes and numbers of leading strobe clocks around these cases.

// File: rtl/fwh_hdr_pkg.sv
package fwh_hdr_pkg;
  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] START_RD = 4'b1101;
  localparam logic [NIB_W-1:0] START_WR = 4'b1110;
  localparam logic [NIB_W-1:0] SIZE_ONE = 4'b0000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_SIZE = 2'd2
  } hdr_state_e;
endpackage

// File: rtl/fwh_start_det.sv
module fwh_start_det
  import fwh_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_nib,
  output logic             hdr_begin,
  output logic             begin_wr
);
  logic             framed_q;
  logic [NIB_W-1:0] start_q;

  // Holds the nibble of the most recent low-strobe clock; the first high clock
  // after it confirms that nibble was the last one, i.e. the start code.
  always_ff @(posedge clk) begin
    if (rst) begin
      framed_q <= 1'b0;
      start_q  <= '0;
    end else begin
      framed_q <= ~frame_n;
      if (!frame_n) start_q <= bus_nib;
    end
  end

  assign hdr_begin = frame_n && framed_q && (start_q == START_RD || start_q == START_WR);
  assign begin_wr  = (start_q == START_WR);
endmodule

// File: rtl/fwh_addr_asm.sv
module fwh_addr_asm
  import fwh_hdr_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  localparam int ADDR_W = NIB_W * ADDR_NIBS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [NIB_W-1:0] stage_q [ADDR_NIBS];

  // Most significant nibble arrives first and ends in the top stage.
  for (genvar i = 0; i < ADDR_NIBS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[i] <= '0;
      end else if (shift_en) begin
        if (i == 0) stage_q[i] <= nib_in;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
    assign addr_out[i*NIB_W +: NIB_W] = stage_q[i];
  end
endmodule

// File: rtl/fwh_hdr_fsm.sv
module fwh_hdr_fsm
  import fwh_hdr_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_nib,
  input  logic [NIB_W-1:0] id_strap,
  input  logic             hdr_begin,
  input  logic             begin_wr,
  output logic             shift_en,
  output logic             emit,
  output logic             emit_wr
);
  localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_NIBS - 1);

  hdr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    wr_d     = wr_q;
    shift_en = 1'b0;
    emit     = 1'b0;
    if (!frame_n) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (hdr_begin && bus_nib == id_strap) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            wr_d    = begin_wr;
          end
        end
        ST_ADDR: begin
          shift_en = 1'b1;
          if (cnt_q == LAST_CNT) state_d = ST_SIZE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        ST_SIZE: begin
          state_d = ST_IDLE;
          emit    = (bus_nib == SIZE_ONE);
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  assign emit_wr = wr_q;

  assert_mismatch_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && hdr_begin && bus_nib != id_strap) |=> state_q == ST_IDLE);

  assert_size_follows_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SIZE) |-> ($past(state_q) == ST_ADDR && $past(cnt_q) == LAST_CNT));

  assert_strobe_resets_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> state_q == ST_IDLE);
endmodule

// File: rtl/fwh_hdr_decoder.sv
module fwh_hdr_decoder
  import fwh_hdr_pkg::*;
#(
  parameter int ADDR_NIBS  = 7,
  parameter int DEC_ADDR_W = 19,
  parameter int REGION_BIT = 22
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_n,
  input  logic [NIB_W-1:0]      bus_nib,
  input  logic [NIB_W-1:0]      id_strap,
  output logic                  req_valid,
  output logic                  req_write,
  output logic                  req_mem,
  output logic [DEC_ADDR_W-1:0] req_addr
);
  localparam int ADDR_W = NIB_W * ADDR_NIBS;

  logic              hdr_begin, begin_wr, shift_en, emit, emit_wr;
  logic [ADDR_W-1:0] addr_full;
  logic              unused_addr_bits;

  fwh_start_det u_start (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .bus_nib   (bus_nib),
    .hdr_begin (hdr_begin),
    .begin_wr  (begin_wr)
  );

  fwh_hdr_fsm #(.ADDR_NIBS(ADDR_NIBS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .bus_nib   (bus_nib),
    .id_strap  (id_strap),
    .hdr_begin (hdr_begin),
    .begin_wr  (begin_wr),
    .shift_en  (shift_en),
    .emit      (emit),
    .emit_wr   (emit_wr)
  );

  fwh_addr_asm #(.ADDR_NIBS(ADDR_NIBS)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .nib_in   (bus_nib),
    .addr_out (addr_full)
  );

  assign unused_addr_bits = ^addr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_mem   <= 1'b0;
      req_addr  <= '0;
    end else begin
      req_valid <= emit;
      if (emit) begin
        req_write <= emit_wr;
        req_mem   <= addr_full[REGION_BIT];
        req_addr  <= addr_full[DEC_ADDR_W-1:0];
      end
    end
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  assert_no_req_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !req_valid);

  assert_size_gate_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($past(bus_nib) == SIZE_ONE && $past(frame_n)));

  assert_reset_clears_R10: assert property (@(posedge clk)
    $past(rst) |-> (!req_valid && req_addr == '0));
endmodule

// File: tb/fwh_hdr_decoder_tb.sv
module fwh_hdr_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_nib = 4'hF;
  logic [3:0]  id_strap = 4'h5;
  logic        req_valid, req_write, req_mem;
  logic [18:0] req_addr;

  int checks = 0, failures = 0, pulses = 0, cyc = 0;
  logic seen_w, seen_m;
  logic [18:0] seen_a;
  bit done = 0;

  fwh_hdr_decoder u_dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .bus_nib(bus_nib), .id_strap(id_strap),
    .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem), .req_addr(req_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    if (req_valid) begin
      pulses++;
      seen_w = req_write; seen_m = req_mem; seen_a = req_addr;
    end
    frame_n = fr;
    bus_nib = nib;
  endtask

  task automatic send_hdr(input logic [3:0] pre, input int nlead, input logic [3:0] st,
                          input logic [3:0] id, input logic [27:0] a, input logic [3:0] sz);
    for (int i = 0; i < nlead - 1; i++) step(1'b0, pre);
    step(1'b0, st);
    step(1'b1, id);
    for (int i = 0; i < 7; i++) step(1'b1, a[27-4*i -: 4]);
    step(1'b1, sz);
  endtask

  function automatic bit exp_ok(input logic [3:0] st, input logic [3:0] id, input logic [3:0] sz);
    return (st == 4'b1101 || st == 4'b1110) && id == id_strap && sz == 4'b0000;
  endfunction

  task automatic check_req(input string tag, input int exp_cnt, input logic ew,
                           input logic em, input logic [18:0] ea);
    checks++;
    if (pulses != exp_cnt || (exp_cnt > 0 && (seen_w != ew || seen_m != em || seen_a != ea))) begin
      failures++;
      $display("FAIL %s: pulses=%0d w=%b m=%b a=%h, expected pulses=%0d w=%b m=%b a=%h",
               tag, pulses, seen_w, seen_m, seen_a, exp_cnt, ew, em, ea);
    end
    pulses = 0;
  endtask

  task automatic finish_hdr_check(input string tag, input logic [3:0] st, input logic [3:0] id,
                                  input logic [27:0] a, input logic [3:0] sz);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    check_req(tag, exp_ok(st, id, sz) ? 1 : 0, st == 4'b1110, a[22], a[18:0]);
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [27:0] a;
    void'($urandom(32'h5EED_1234));
    // R10: reset state
    rst = 1'b1;
    repeat (3) step(1'b1, 4'hF);
    @(negedge clk); rst = 1'b0;
    step(1'b1, 4'hF);
    checks++;
    if (req_valid || req_write || req_mem || req_addr != 0) begin
      failures++;
      $display("FAIL R10 reset: v=%b w=%b m=%b a=%h expected all zero", req_valid, req_write, req_mem, req_addr);
    end
    pulses = 0;

    // R1 R4 R5 R9: read to memory array
    a = 28'h0412345;
    send_hdr(4'h0, 1, 4'b1101, 4'h5, a, 4'h0);
    finish_hdr_check("R1/R4/R5/R9 read memory", 4'b1101, 4'h5, a, 4'h0);

    // R6: write to register space with ignored bits all set
    a = 28'hFBB_CDEF;
    send_hdr(4'h0, 1, 4'b1110, 4'h5, a, 4'h0);
    finish_hdr_check("R6/R5 write regs ignored bits", 4'b1110, 4'h5, a, 4'h0);

    // R3: select mismatch
    a = 28'h0400001;
    send_hdr(4'h0, 1, 4'b1101, 4'h6, a, 4'h0);
    finish_hdr_check("R3 id mismatch", 4'b1101, 4'h6, a, 4'h0);

    // R2: bad start code
    send_hdr(4'h0, 1, 4'b1100, 4'h5, a, 4'h0);
    finish_hdr_check("R2 bad start", 4'b1100, 4'h5, a, 4'h0);

    // R1: multi-clock strobe, last nibble wins (valid last)
    a = 28'h0055555;
    send_hdr(4'b1110, 2, 4'b1101, 4'h5, a, 4'h0);
    finish_hdr_check("R1 last low nibble read", 4'b1101, 4'h5, a, 4'h0);

    // R1: valid nibble first, invalid last
    send_hdr(4'b1101, 3, 4'b1100, 4'h5, a, 4'h0);
    finish_hdr_check("R1 last low nibble invalid", 4'b1100, 4'h5, a, 4'h0);

    // R7: unsupported size
    send_hdr(4'h0, 1, 4'b1110, 4'h5, a, 4'h1);
    finish_hdr_check("R7 size 0001", 4'b1110, 4'h5, a, 4'h1);

    // R8: strobe low mid-address restarts with the new start nibble
    step(1'b0, 4'b1101); step(1'b1, 4'h5); step(1'b1, 4'h0); step(1'b1, 4'h4);
    a = 28'h0477777;
    send_hdr(4'h0, 1, 4'b1110, 4'h5, a, 4'h0);
    finish_hdr_check("R8 abort then restart", 4'b1110, 4'h5, a, 4'h0);

    // R8: strobe low on the size clock drops the header
    step(1'b0, 4'b1101); step(1'b1, 4'h5);
    for (int i = 0; i < 7; i++) step(1'b1, 4'h3);
    step(1'b0, 4'h0);
    step(1'b1, 4'hF); step(1'b1, 4'hF);
    check_req("R8 strobe on size clock", 0, 1'b0, 1'b0, 19'h0);

    // R11: back-to-back headers
    send_hdr(4'h0, 1, 4'b1101, 4'h5, 28'h0400ABC, 4'h0);
    a = 28'h0000DEF;
    send_hdr(4'h0, 1, 4'b1110, 4'h5, a, 4'h0);
    step(1'b1, 4'hF); step(1'b1, 4'hF);
    check_req("R11 back-to-back", 2, 1'b1, 1'b0, a[18:0]);

    // R10: reset mid-header drops it and clears outputs
    step(1'b0, 4'b1101); step(1'b1, 4'h5); step(1'b1, 4'h0); step(1'b1, 4'h4);
    @(negedge clk); rst = 1'b1;
    step(1'b1, 4'h1);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 4'h2);
    step(1'b1, 4'h0);
    step(1'b1, 4'hF); step(1'b1, 4'hF);
    check_req("R10 reset mid-header", 0, 1'b0, 1'b0, 19'h0);
    checks++;
    if (req_addr != 0 || req_write || req_mem) begin
      failures++;
      $display("FAIL R10 outputs after reset: w=%b m=%b a=%h expected zero", req_write, req_mem, req_addr);
    end

    // Seeded random headers (R1 R2 R3 R4 R5 R7)
    for (int n = 0; n < 80; n++) begin
      logic [3:0] st, id, sz, pre;
      int nlead;
      if (n % 16 == 15) id_strap = 4'($urandom);
      st = ($urandom % 4 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'b1101 : 4'b1110);
      id = ($urandom % 4 == 0) ? 4'($urandom) : id_strap;
      sz = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
      pre = 4'($urandom);
      nlead = 1 + int'($urandom % 3);
      a = 28'($urandom);
      send_hdr(pre, nlead, st, id, a, sz);
      finish_hdr_check("R1/R2/R3/R4/R5/R7 random", st, id, a, sz);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule